// File: doc/BRIEF.md
# Load Data Byte Formatter

This block sits at the end of a 64-bit load path and turns raw memory doublewords into a register value. It receives a doubleword, the byte offset of the access within it, an access size of 1, 2, 4 or 8 bytes, and flags asking for byte reversal, sign extension and a condition record. A single crossbar of byte multiplexers rotates the data and, when asked, reverses it in the same step. Per-byte logic then clears or sign-fills the bytes above the access size.

Some loads start near the end of a doubleword and run into the next one. For these the block takes two beats. The bytes of the first doubleword, already rotated, are kept in a one-entry holding register. On the second beat each output byte is taken from either the held bytes or the new doubleword. When the record flag is set, the result is also compared with zero to produce a 4-bit condition field.

Top module: `ldfmt`

## Requirements
- R1: Byte k of a doubleword is bits 8k+7..8k. Memory byte k is byte k of the first doubleword for k<8 and byte k-8 of the second for k>=8. In normal order, result byte i equals memory byte offset+i for every i below the access size n.
- R2: With `in_reverse` set, result byte i equals memory byte offset+n-1-i for i<n.
- R3: `in_size` codes 0, 1, 2 and 3 select 1, 2, 4 and 8 bytes. With `in_sign` clear, every result byte at index n or above is zero.
- R4: With `in_sign` set, every result byte at index n or above is 0xFF when bit 7 of result byte n-1 is 1, and 0x00 otherwise.
- R5: An access with offset+n > 8 takes two `in_valid` beats, the lower doubleword first, with the same controls on both. The first beat produces no output.
- R6: An access with offset+n <= 8 completes in the single beat that presents it.
- R7: `out_valid` is high for exactly the one cycle after the final beat of an access. `out_data` holds its value while `out_valid` is low.
- R8: With `in_record` set, `out_cr_en` rises with `out_valid` and `out_cr` = {LT, GT, EQ, SO}. LT is result bit 63, EQ means the result is zero, GT means neither, and SO copies `in_so` from the final beat.
- R9: With `in_record` clear, `out_cr_en` and `out_cr` are 0.
- R10: Synchronous reset clears `out_valid`, `out_cr_en` and any half-finished two-beat access. After reset, the next beat is treated as the first beat of a new access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Doubleword beat present |
| in_dword | input | 64 | Memory doubleword |
| in_offset | input | 3 | Byte offset of the access |
| in_size | input | 2 | Access size code |
| in_reverse | input | 1 | Byte-reverse the result |
| in_sign | input | 1 | Sign-extend the result |
| in_record | input | 1 | Produce a condition field |
| in_so | input | 1 | Summary overflow to copy into the condition |
| out_valid | output | 1 | Result valid |
| out_data | output | 64 | Formatted result |
| out_cr_en | output | 1 | Condition field valid |
| out_cr | output | 4 | {LT, GT, EQ, SO} |

## Verification
The assertions assume that a two-beat access presents identical control fields on both beats, so that the offset and size seen on the second beat describe the access the first beat opened. They also use the fact that a one-byte access can never cross a doubleword boundary. The stimulus tasks drive every access as a unit: they hold the controls steady across both beats, lower `in_valid` between accesses, and only break a pair on purpose in the reset test. The bench then sweeps every offset, size, reverse and sign combination over several data patterns against an independent memory-image model.

// File: rtl/ldfmt.sv
module ldfmt #(
  parameter int NB = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [8*NB-1:0] in_dword,
  input  logic [2:0]      in_offset,
  input  logic [1:0]      in_size,
  input  logic            in_reverse,
  input  logic            in_sign,
  input  logic            in_record,
  input  logic            in_so,
  output logic            out_valid,
  output logic [8*NB-1:0] out_data,
  output logic            out_cr_en,
  output logic [3:0]      out_cr
);
  localparam int DW = 8 * NB;
  localparam int OW = $clog2(NB);
  localparam int PW = OW + 1;

  logic          pend;
  logic [DW-1:0] held;
  logic [DW-1:0] rot;
  logic [DW-1:0] asm_d;
  logic [DW-1:0] res;
  logic [NB-1:0] keep;
  logic [PW-1:0] nbytes;
  logic          span, fire, sbit;

  assign nbytes = PW'(1) << in_size;
  assign span   = ({1'b0, in_offset} + nbytes) > PW'(NB);
  assign fire   = in_valid && (pend || !span);

  for (genvar i = 0; i < NB; i++) begin : g_byte
    logic [PW-1:0] pos;
    assign pos = in_reverse ? ({1'b0, in_offset} + nbytes - PW'(1) - PW'(i))
                            : ({1'b0, in_offset} + PW'(i));
    assign rot[8*i +: 8]   = in_dword[8*pos[OW-1:0] +: 8];
    assign asm_d[8*i +: 8] = (pend && !pos[OW]) ? held[8*i +: 8] : rot[8*i +: 8];
    assign keep[i]         = PW'(i) < nbytes;
  end

  always_comb begin
    sbit = 1'b0;
    for (int k = 0; k < NB; k++)
      if (PW'(k) == nbytes - PW'(1)) sbit = asm_d[8*k+7];
  end

  for (genvar i = 0; i < NB; i++) begin : g_trim
    assign res[8*i +: 8] = keep[i] ? asm_d[8*i +: 8] : {8{in_sign & sbit}};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend      <= 1'b0;
      held      <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_cr_en <= 1'b0;
      out_cr    <= '0;
    end else begin
      out_valid <= fire;
      out_cr_en <= fire && in_record;
      if (in_valid) pend <= pend ? 1'b0 : span;
      if (in_valid && !pend && span) held <= rot;
      if (fire) begin
        out_data <= res;
        out_cr   <= in_record ? {res[DW-1], !res[DW-1] && (|res), ~|res, in_so} : 4'b0;
      end
    end
  end
endmodule

// File: rtl/ldfmt_chk.sv
module ldfmt_chk (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic [2:0]  in_offset,
  input logic [1:0]  in_size,
  input logic        in_sign,
  input logic        pend,
  input logic        out_valid,
  input logic [63:0] out_data,
  input logic        out_cr_en,
  input logic [3:0]  out_cr
);
  logic crosses;
  assign crosses = ({1'b0, in_offset} + (4'd1 << in_size)) > 4'd8;

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> !out_valid && !out_cr_en); // R10
  AST_NO_BEAT_NO_OUT: assert property (@(posedge clk) disable iff (rst) !in_valid |=> !out_valid); // R7
  AST_FIRST_BEAT_SILENT: assert property (@(posedge clk) disable iff (rst) in_valid && !pend && crosses |=> !out_valid); // R5
  AST_SHORT_ONE_BEAT: assert property (@(posedge clk) disable iff (rst) in_valid && !pend && !crosses |=> out_valid); // R6
  AST_BYTE_ZERO_EXT: assert property (@(posedge clk) disable iff (rst) in_valid && !pend && in_size == 2'd0 && !in_sign |=> out_data[63:8] == 56'd0); // R3
  AST_CR_WITH_VALID: assert property (@(posedge clk) disable iff (rst) out_cr_en |-> out_valid); // R8
  AST_CR_ONE_FLAG: assert property (@(posedge clk) disable iff (rst) out_cr_en |-> $onehot(out_cr[3:1])); // R8
  AST_CR_EQ_ZERO: assert property (@(posedge clk) disable iff (rst) out_cr_en |-> (out_cr[1] == (out_data == 64'd0))); // R8
  AST_CR_LT_SIGN: assert property (@(posedge clk) disable iff (rst) out_cr_en |-> (out_cr[3] == out_data[63])); // R8
  AST_CR_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst) out_valid && !out_cr_en |-> out_cr == 4'd0); // R9
endmodule

bind ldfmt ldfmt_chk u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_offset(in_offset),
  .in_size(in_size), .in_sign(in_sign), .pend(pend), .out_valid(out_valid),
  .out_data(out_data), .out_cr_en(out_cr_en), .out_cr(out_cr)
);

// File: tb/sim_ldfmt.sv
module sim_ldfmt;
  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 1'b0, in_reverse = 1'b0, in_sign = 1'b0, in_record = 1'b0, in_so = 1'b0;
  logic [63:0] in_dword = '0;
  logic [2:0]  in_offset = '0;
  logic [1:0]  in_size = '0;
  logic        out_valid, out_cr_en;
  logic [63:0] out_data;
  logic [3:0]  out_cr;
  int tests = 0, fails = 0;

  always #2 clk = ~clk;

  ldfmt u0 (.clk(clk), .rst(rst), .in_valid(in_valid), .in_dword(in_dword),
    .in_offset(in_offset), .in_size(in_size), .in_reverse(in_reverse), .in_sign(in_sign),
    .in_record(in_record), .in_so(in_so), .out_valid(out_valid), .out_data(out_data),
    .out_cr_en(out_cr_en), .out_cr(out_cr));

  localparam logic [127:0] PATS [4] = '{
    128'h8F8E8D8C8B8A8988_0706050403020100,
    128'h0123456789ABCDEF_FEDCBA9876543210,
    128'h7F80FF00817E0102_807F01FE00FF7F80,
    128'h0000000000000000_FFFFFFFFFFFFFFFF
  };

  function automatic logic [63:0] ref_fmt(input logic [127:0] mem, input int off,
      input int sz, input bit rev, input bit sgn);
    int n = 1 << sz;
    logic [63:0] r = '0;
    for (int i = 0; i < n; i++) begin
      int src = rev ? off + n - 1 - i : off + i;
      r[8*i +: 8] = mem[8*src +: 8];
    end
    if (sgn && r[8*n-1])
      for (int i = n; i < 8; i++) r[8*i +: 8] = 8'hFF;
    return r;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic [127:0] mem, input int off, input int sz,
      input bit rev, input bit sgn, input bit rec, input bit so, input string req);
    bit crossing = (off + (1 << sz)) > 8;
    @(negedge clk);
    in_valid = 1; in_dword = mem[63:0]; in_offset = 3'(off); in_size = 2'(sz);
    in_reverse = rev; in_sign = sgn; in_record = rec; in_so = so;
    if (crossing) begin
      @(negedge clk);
      chk("R5 first beat silent", {63'd0, out_valid}, 64'd0);
      in_dword = mem[127:64];
    end
    @(negedge clk);
    in_valid = 0;
    chk({req, " valid"}, {63'd0, out_valid}, 64'd1);
    chk(req, out_data, ref_fmt(mem, off, sz, rev, sgn));
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog timeout actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 reset valid", {62'd0, out_valid, out_cr_en}, 64'd0);
    rst = 0;
    for (int p = 0; p < 4; p++)
      for (int off = 0; off < 8; off++)
        for (int sz = 0; sz < 4; sz++)
          for (int m = 0; m < 4; m++) begin
            bit rev = m[0];
            bit sgn = m[1];
            access(PATS[p], off, sz, rev, sgn, 0, 0,
              rev ? "R2 reversed" : (sgn ? "R4 sign fill" : "R1 R3 normal"));
          end

    access(128'h0, 2, 0, 0, 0, 1, 0, "R8 zero byte");
    chk("R8 cr EQ", {59'd0, out_cr_en, out_cr}, 64'h12);
    access({64'h0, 64'h0000_0000_0080_0000}, 2, 0, 0, 1, 1, 1, "R8 negative");
    chk("R8 cr LT SO", {59'd0, out_cr_en, out_cr}, 64'h19);
    access({64'h05, 64'h0}, 7, 1, 0, 1, 1, 0, "R8 crossing positive");
    chk("R8 cr GT", {59'd0, out_cr_en, out_cr}, 64'h14);
    access(PATS[0], 0, 3, 0, 0, 0, 1, "R9 no record");
    chk("R9 cr off", {59'd0, out_cr_en, out_cr}, 64'h0);

    @(negedge clk);
    chk("R7 single pulse", {63'd0, out_valid}, 64'd0);
    chk("R7 data held", out_data, PATS[0][63:0]);

    @(negedge clk);
    in_valid = 1; in_dword = PATS[1][63:0]; in_offset = 3'd6; in_size = 2'd2;
    in_reverse = 0; in_sign = 0; in_record = 0;
    @(negedge clk);
    in_valid = 0; rst = 1;
    @(negedge clk);
    rst = 0;
    chk("R10 reset mid access", {63'd0, out_valid}, 64'd0);
    access(PATS[2], 1, 1, 0, 0, 0, 0, "R10 R6 fresh after reset");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule